// File: doc/BRIEF.md
# BCD calendar clock counter

This block keeps wall-clock time from seconds up to years, every field held in packed BCD. It runs on a 32768 Hz reference clock. An internal prescaler turns that clock into a one-cycle pulse once per second, and each pulse advances the seconds field. Carries ripple upward through minutes, hours, weekday, day of month, month and year. Counting is always 24-hour. February has 28 or 29 days, chosen by a leap flag that the host stores next to the year. The block does not compute leap years itself.

A host reaches the block through a synchronous word-addressed register port. Writes to the seven time fields go into a shadow copy and do not change the running time. The shadow copy is loaded into the live counters as a whole when the host writes the trigger word with its top bit set. That load also restarts the prescaler, so the first second after a set lasts a full second. Reads always return the live counters and arrive one cycle after the address.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the live time reads seconds 0x00, minutes 0x00, hours 0x00, weekday 0, day 0x01, month 0x01, year 0x00 with the leap flag clear. The trigger word reads 0x0000 and the control word reads 0x0001.
- R2: The prescaler emits a one-cycle `sec_tick` every 2^PRESCALE_W clock cycles. Each tick advances seconds by one BCD step. Between ticks no live field changes.
- R3: Seconds count in BCD from 0x00 to 0x59. After 0x59 they go to 0x00 and carry into minutes. Minutes wrap 0x59 to 0x00 in the same way and carry into hours.
- R4: Hours count 0x00 to 0x23. After 0x23 they go to 0x00 and carry into both the day of month and the weekday. The weekday counts 0 to 6 and wraps from 6 to 0.
- R5: The day of month wraps to 0x01 after the last day of the month. Months 0x04, 0x06, 0x09 and 0x11 have 0x30 days. Month 0x02 has 0x29 days when the leap flag (bit 15 of the year word) is 1 and 0x28 days when it is 0. All other months have 0x31 days.
- R6: A wrap of the day carries into the month. The month counts 0x01 to 0x12, wraps to 0x01 and carries into the year. The year counts 0x00 to 0x99 and wraps to 0x00. Rollover never changes the leap flag.
- R7: The register map is: word 0 seconds [6:0], word 1 minutes [6:0], word 2 hours [5:0], word 3 weekday [2:0], word 4 day [5:0], word 5 month [4:0], word 6 year [7:0] with the leap flag at [15], word 7 trigger [15], word 8 control [0]. Writes to words 0 to 6 change only the shadow copy and leave the read values unchanged. A write to word 7 with bit 15 clear changes nothing.
- R8: A write to word 7 with bit 15 set makes word 7 read 0x8000 for one cycle. In the next cycle all seven live fields and the leap flag take their shadow values. Word 7 then reads 0x0000. The next tick comes 2^PRESCALE_W cycles after the load cycle.
- R9: When the load cycle falls on a tick cycle, the load wins. The live seconds take the shadow value, not an incremented one.
- R10: Read data is registered and shows the word addressed in the previous cycle. Unmapped words and unused bits read 0.
- R11: Bit 0 of the control word (the 24-hour select) can be written and read back. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sec_tick | output | 1 | One-cycle once-per-second pulse |

## Verification
The range assertions assume that the host only loads legal calendar values: valid BCD digits, seconds and minutes no higher than 0x59, hours no higher than 0x23, a month from 0x01 to 0x12, and a day no later than the last day of that month. An out-of-range load would keep counting past the wrap point and break those properties. The stimulus table and the directed tests therefore stage only legal dates. They include every month-length case, both values of the leap flag, and the full end-of-year carry. A load is made to land exactly on a tick cycle to exercise the priority rule.

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int PRESCALE_W = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sec_tick
);

  logic [PRESCALE_W-1:0] presc;

  logic [6:0] sec, mins;
  logic [5:0] hour, day;
  logic [2:0] wday;
  logic [4:0] mon;
  logic [7:0] year;
  logic       leap;

  logic [6:0] s_sec, s_mins;
  logic [5:0] s_hour, s_day;
  logic [2:0] s_wday;
  logic [4:0] s_mon;
  logic [7:0] s_year;
  logic       s_leap;

  logic pending;
  logic ctrl24;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[14:8];

  // prescaler
  assign sec_tick = &presc;

  always_ff @(posedge clk) begin
    if (!rst_n || pending) presc <= '0;
    else                   presc <= presc + 1'b1;
  end

  // increments and wrap detection
  logic [6:0] sec_inc, mins_inc;
  logic [5:0] hour_inc, day_inc;
  logic [4:0] mon_inc;
  logic [7:0] year_inc;
  logic [2:0] wday_inc;
  logic [5:0] month_len;

  assign sec_inc  = (sec[3:0]  == 4'd9) ? {sec[6:4]  + 3'd1, 4'd0} : sec  + 7'd1;
  assign mins_inc = (mins[3:0] == 4'd9) ? {mins[6:4] + 3'd1, 4'd0} : mins + 7'd1;
  assign hour_inc = (hour[3:0] == 4'd9) ? {hour[5:4] + 2'd1, 4'd0} : hour + 6'd1;
  assign day_inc  = (day[3:0]  == 4'd9) ? {day[5:4]  + 2'd1, 4'd0} : day  + 6'd1;
  assign mon_inc  = (mon[3:0]  == 4'd9) ? {mon[4]    + 1'b1, 4'd0} : mon  + 5'd1;
  assign year_inc = (year[3:0] == 4'd9) ? {year[7:4] + 4'd1, 4'd0} : year + 8'd1;
  assign wday_inc = (wday == 3'd6) ? 3'd0 : wday + 3'd1;

  always_comb begin
    case (mon)
      5'h02:                      month_len = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: month_len = 6'h30;
      default:                    month_len = 6'h31;
    endcase
  end

  logic c_min, c_hour, c_day, c_mon, c_year;

  assign c_min  = sec_tick & (sec  == 7'h59);
  assign c_hour = c_min    & (mins == 7'h59);
  assign c_day  = c_hour   & (hour == 6'h23);
  assign c_mon  = c_day    & (day  == month_len);
  assign c_year = c_mon    & (mon  == 5'h12);

  // live counters
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= 7'h00;
      mins <= 7'h00;
      hour <= 6'h00;
      wday <= 3'd0;
      day  <= 6'h01;
      mon  <= 5'h01;
      year <= 8'h00;
      leap <= 1'b0;
    end else if (pending) begin
      sec  <= s_sec;
      mins <= s_mins;
      hour <= s_hour;
      wday <= s_wday;
      day  <= s_day;
      mon  <= s_mon;
      year <= s_year;
      leap <= s_leap;
    end else begin
      if (sec_tick) sec  <= c_min  ? 7'h00 : sec_inc;
      if (c_min)    mins <= c_hour ? 7'h00 : mins_inc;
      if (c_hour)   hour <= c_day  ? 6'h00 : hour_inc;
      if (c_day)    wday <= wday_inc;
      if (c_day)    day  <= c_mon  ? 6'h01 : day_inc;
      if (c_mon)    mon  <= c_year ? 5'h01 : mon_inc;
      if (c_year)   year <= (year == 8'h99) ? 8'h00 : year_inc;
    end
  end

  // shadow registers, trigger and control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_sec   <= 7'h00;
      s_mins  <= 7'h00;
      s_hour  <= 6'h00;
      s_wday  <= 3'd0;
      s_day   <= 6'h01;
      s_mon   <= 5'h01;
      s_year  <= 8'h00;
      s_leap  <= 1'b0;
      pending <= 1'b0;
      ctrl24  <= 1'b1;
    end else begin
      pending <= bus_we && bus_addr == 4'd7 && bus_wdata[15];
      if (bus_we) begin
        case (bus_addr)
          4'd0: s_sec  <= bus_wdata[6:0];
          4'd1: s_mins <= bus_wdata[6:0];
          4'd2: s_hour <= bus_wdata[5:0];
          4'd3: s_wday <= bus_wdata[2:0];
          4'd4: s_day  <= bus_wdata[5:0];
          4'd5: s_mon  <= bus_wdata[4:0];
          4'd6: begin
            s_year <= bus_wdata[7:0];
            s_leap <= bus_wdata[15];
          end
          4'd8: ctrl24 <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else begin
      case (bus_addr)
        4'd0:    bus_rdata <= {9'd0, sec};
        4'd1:    bus_rdata <= {9'd0, mins};
        4'd2:    bus_rdata <= {10'd0, hour};
        4'd3:    bus_rdata <= {13'd0, wday};
        4'd4:    bus_rdata <= {10'd0, day};
        4'd5:    bus_rdata <= {11'd0, mon};
        4'd6:    bus_rdata <= {leap, 7'd0, year};
        4'd7:    bus_rdata <= {pending, 15'd0};
        4'd8:    bus_rdata <= {15'd0, ctrl24};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // assertions
  assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec[3:0] <= 4'd9 && sec <= 7'h59 && mins[3:0] <= 4'd9 && mins <= 7'h59);

  assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hour[3:0] <= 4'd9 && hour <= 6'h23 && wday <= 3'd6);

  assert_day_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    day >= 6'h01 && day[3:0] <= 4'd9 && day <= month_len);

  assert_mon_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mon >= 5'h01 && mon <= 5'h12 && mon[3:0] <= 4'd9 && year[3:0] <= 4'd9);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick && !pending |=> $stable(sec) && $stable(day) && $stable(year));

  assert_leap_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(leap));

  assert_commit_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> sec == $past(s_sec) && mon == $past(s_mon) && presc == '0);

  assert_commit_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pending && sec_tick |=> sec == $past(s_sec));

endmodule

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
  localparam int PW = 6;
  localparam int PERIOD = 1 << PW;
  localparam int NVEC = 15;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic sec_tick;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_calendar_clock #(.PRESCALE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick));

  // {sec,min,hour,wday,day,mon,year,leap} start, then expected after one tick
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h00_00_00_00_01_01_00_00, 64'h01_00_00_00_01_01_00_00},
    {64'h59_34_12_03_15_06_25_00, 64'h00_35_12_03_15_06_25_00},
    {64'h59_59_09_05_20_07_30_00, 64'h00_00_10_05_20_07_30_00},
    {64'h59_59_23_06_10_03_50_00, 64'h00_00_00_00_11_03_50_00},
    {64'h59_59_23_02_30_04_11_00, 64'h00_00_00_03_01_05_11_00},
    {64'h59_59_23_01_31_01_12_01, 64'h00_00_00_02_01_02_12_01},
    {64'h59_59_23_04_28_02_13_00, 64'h00_00_00_05_01_03_13_00},
    {64'h59_59_23_04_28_02_14_01, 64'h00_00_00_05_29_02_14_01},
    {64'h59_59_23_00_29_02_14_01, 64'h00_00_00_01_01_03_14_01},
    {64'h59_59_23_03_31_12_99_00, 64'h00_00_00_04_01_01_00_00},
    {64'h59_59_23_03_31_12_69_00, 64'h00_00_00_04_01_01_70_00},
    {64'h59_59_23_05_30_11_40_00, 64'h00_00_00_06_01_12_40_00},
    {64'h59_59_23_05_30_10_40_00, 64'h00_00_00_06_31_10_40_00},
    {64'h59_59_23_02_30_09_41_00, 64'h00_00_00_03_01_10_41_00},
    {64'h59_09_23_02_30_09_41_00, 64'h00_10_23_02_30_09_41_00}
  };

  function automatic logic [15:0] word_of(logic [63:0] v, int f);
    logic [7:0] b;
    b = v[63 - 8*f -: 8];
    if (f == 6) return {v[0], 7'd0, b};
    return {8'd0, b};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_tick();
    while (sec_tick !== 1'b1) @(negedge clk);
  endtask

  task automatic count_to_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (sec_tick !== 1'b1 && n < 4*PERIOD);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values, R10 unmapped read, R11 control
    begin
      logic [63:0] rv;
      rv = 64'h00_00_00_00_01_01_00_00;
      for (int f = 0; f < 7; f++) begin
        rd(f[3:0], r); check("R1 reset field", r, word_of(rv, f));
      end
    end
    rd(4'd7, r); check("R1 trigger reset", r, 16'h0000);
    rd(4'd8, r); check("R1 control reset", r, 16'h0001);
    rd(4'd12, r); check("R10 unmapped read", r, 16'h0000);
    wr(4'd8, 16'h0000); rd(4'd8, r); check("R11 control clear", r, 16'h0000);
    wr(4'd8, 16'hFFFF); rd(4'd8, r); check("R11 control set", r, 16'h0001);

    // vector table: load, read back, one tick, read back
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] st, ex;
      st = VEC[i][127:64];
      ex = VEC[i][63:0];
      for (int f = 0; f < 7; f++) wr(f[3:0], word_of(st, f));
      wr(4'd7, 16'h8000);
      @(negedge clk);
      for (int f = 0; f < 7; f++) begin
        rd(f[3:0], r); check("R8 load value", r, word_of(st, f));
      end
      wait_tick();
      @(negedge clk);
      for (int f = 0; f < 7; f++) begin
        rd(f[3:0], r); check("R3 R4 R5 R6 rollover", r, word_of(ex, f));
      end
    end

    // R2 tick period
    wait_tick();
    count_to_tick(n);
    check("R2 tick period", n[15:0], PERIOD[15:0]);

    // R7 shadow writes hidden; R8 trigger readback and restart
    wr(4'd0, 16'h0010);
    wr(4'd7, 16'h8000);
    @(negedge clk);
    wr(4'd0, 16'h0045);
    wr(4'd7, 16'h0000);
    rd(4'd0, r); check("R7 shadow hidden", r, 16'h0010);
    @(negedge clk);
    rd(4'd0, r); check("R7 trigger bit clear ignored", r, 16'h0010);
    bus_addr = 4'd7;
    wr(4'd7, 16'h8000);
    @(negedge clk); check("R8 trigger pending", bus_rdata, 16'h8000);
    @(negedge clk); check("R8 trigger cleared", bus_rdata, 16'h0000);
    rd(4'd0, r); check("R8 committed seconds", r, 16'h0045);
    wr(4'd0, 16'h0030);
    wr(4'd7, 16'h8000);
    count_to_tick(n);
    check("R8 prescaler restart", n[15:0], PERIOD[15:0]);

    // R9 load on a tick cycle
    wr(4'd0, 16'h0020);
    wait_tick();
    repeat (PERIOD - 1) @(negedge clk);
    wr(4'd7, 16'h8000);
    check("R9 tick coincides", {15'd0, sec_tick}, 16'h0001);
    @(negedge clk);
    rd(4'd0, r); check("R9 load wins", r, 16'h0020);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule